// File: doc/BRIEF.md
# Paged Frame Transmit Launcher

This block sends one frame that software has already placed in the local packet buffer memory. Software chooses a 256-byte page in that buffer and a 16-bit byte count through a small byte-wide register window. It then writes the launch bit of the command register. The block reads the frame from buffer memory one byte at a time, starting at the first byte of the chosen page. It hands each byte to a valid/ready byte stream that stands in for the medium. When it finishes, it records the outcome in interrupt status bits and in a transmit status byte.

The launch bit is also the busy flag: it reads back as 1 for as long as a frame is in flight. Frames shorter than the minimum length go out with zero bytes appended until they reach it. A fault reported by the medium ends the frame early, and so does a STOP command. Either one is reported as a transmit error.

Top module: `pkt_tx_launcher`

## Requirements
- R1: After reset the command register (offset 0x0) reads 0x01, the interrupt status register (offset 0x7) reads 0x00, and neither tx_valid nor mem_rd is asserted.
- R2: A command write with bit 0 set stops the controller. A command write with bit 1 set and bit 0 clear starts it. The command register reads bit 0 = stopped and bit 1 = started. A command write that lacks bit 1, or that carries bit 0, never launches a frame.
- R3: A command write with bit 2 and bit 1 set and bit 0 clear, made while idle, launches a frame. Command bit 2 reads 1 from the next cycle until the frame ends.
- R4: Offset 0x4 (write) holds the start page, offset 0x5 the low count byte and offset 0x6 the high count byte. Stored byte i of the frame is read from buffer address page*256+i.
- R5: Frame bytes leave on tx_data in buffer order. While tx_valid is high and tx_ready is low, tx_data and tx_valid hold.
- R6: In the cycle after the last byte is accepted, command bit 2 reads 0 and interrupt status bit 1 is set, both at once. The transmit status byte then reads bit 0 = 1.
- R7: When the count is below 64, the stored bytes are followed by zero bytes to make 64 in total. A count of 0 sends 64 zero bytes. A count of 64 or more sends exactly that many bytes.
- R8: A launch write made while a frame is in flight is ignored. The running frame keeps its original page and length.
- R9: tx_fault high, or a STOP command write, while busy ends the frame at once. tx_valid drops, command bit 2 clears, interrupt status bit 3 sets, bit 1 does not, and the transmit status byte reads 0x02.
- R10: Writing to offset 0x7 clears exactly those interrupt status bits written as 1.
- R11: A read of offset 0x4 returns the transmit status byte (bit 0 completed, bit 1 aborted, cleared at each launch), never the start page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational on host_addr) |
| mem_addr | output | ADDR_W | Buffer memory byte address |
| mem_rd | output | 1 | Buffer read request; data returns one cycle later |
| mem_rdata | input | 8 | Buffer read data |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_ready | input | 1 | Medium accepts the byte |
| tx_fault | input | 1 | Medium reports a transmit error |

## Verification
The bench goes after the exact cycle in which the busy bit falls relative to the last handshake. A design that clears it one cycle late, or clears it before the byte is taken, breaks the polling contract. Short, empty and exactly-minimum frames check the padding edge. A wrong comparison there would drop, repeat or garble the zero tail, or pad a frame that needs none. Relaunch attempts while busy, launches without the start bit, and faults or STOP commands mid-frame show whether stray commands can corrupt the frame in flight or leave the error flag unset. Randomised back-pressure shows whether bytes are lost or repeated when the medium stalls.

// File: rtl/txl_pkg.sv
package txl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LOAD,
      ST_SEND
   } txl_state_e;

   localparam logic [3:0] OFS_CMD     = 4'h0;
   localparam logic [3:0] OFS_PAGE    = 4'h4;
   localparam logic [3:0] OFS_CNT_LO  = 4'h5;
   localparam logic [3:0] OFS_CNT_HI  = 4'h6;
   localparam logic [3:0] OFS_IRQ     = 4'h7;

   localparam int CMD_STOP_B  = 0;
   localparam int CMD_START_B = 1;
   localparam int CMD_TXGO_B  = 2;
   localparam int IRQ_DONE_B  = 1;
   localparam int IRQ_ERR_B   = 3;
   localparam int TST_OK_B    = 0;
   localparam int TST_ABT_B   = 1;
endpackage

// File: rtl/txl_regs.sv
module txl_regs
   import txl_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        host_addr,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic              err_i,
   output logic              go_o,
   output logic              abort_o,
   output logic [PAGE_W-1:0] page_o,
   output logic [CNT_W-1:0]  count_o
);
   logic              run_q;
   logic [PAGE_W-1:0] page_q;
   logic [CNT_W-1:0]  count_q;
   logic              irq_done_q, irq_err_q;
   logic              tst_ok_q, tst_abt_q;
   logic              wr_cmd, wr_page, wr_lo, wr_hi, wr_irq;

   assign wr_cmd  = host_wr && (host_addr == OFS_CMD);
   assign wr_page = host_wr && (host_addr == OFS_PAGE);
   assign wr_lo   = host_wr && (host_addr == OFS_CNT_LO);
   assign wr_hi   = host_wr && (host_addr == OFS_CNT_HI);
   assign wr_irq  = host_wr && (host_addr == OFS_IRQ);

   assign go_o    = wr_cmd && host_wdata[CMD_TXGO_B] && host_wdata[CMD_START_B]
                    && !host_wdata[CMD_STOP_B] && !busy_i;
   assign abort_o = wr_cmd && host_wdata[CMD_STOP_B] && busy_i;
   assign page_o  = page_q;
   assign count_o = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         page_q     <= '0;
         count_q    <= '0;
         irq_done_q <= 1'b0;
         irq_err_q  <= 1'b0;
         tst_ok_q   <= 1'b0;
         tst_abt_q  <= 1'b0;
      end else begin
         if (wr_cmd) begin
            if (host_wdata[CMD_STOP_B])       run_q <= 1'b0;
            else if (host_wdata[CMD_START_B]) run_q <= 1'b1;
         end
         if (wr_page) page_q <= host_wdata[PAGE_W-1:0];
         if (wr_lo)   count_q[7:0] <= host_wdata;
         if (wr_hi)   count_q[CNT_W-1:8] <= host_wdata[CNT_W-9:0];
         irq_done_q <= done_i | (irq_done_q & ~(wr_irq & host_wdata[IRQ_DONE_B]));
         irq_err_q  <= err_i  | (irq_err_q  & ~(wr_irq & host_wdata[IRQ_ERR_B]));
         tst_ok_q   <= done_i | (tst_ok_q  & ~go_o);
         tst_abt_q  <= err_i  | (tst_abt_q & ~go_o);
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         OFS_CMD: begin
            host_rdata[CMD_STOP_B]  = ~run_q;
            host_rdata[CMD_START_B] = run_q;
            host_rdata[CMD_TXGO_B]  = busy_i;
         end
         OFS_PAGE: begin
            host_rdata[TST_OK_B]  = tst_ok_q;
            host_rdata[TST_ABT_B] = tst_abt_q;
         end
         OFS_IRQ: begin
            host_rdata[IRQ_DONE_B] = irq_done_q;
            host_rdata[IRQ_ERR_B]  = irq_err_q;
         end
         default: host_rdata = '0;
      endcase
   end

   AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) done_i |=> irq_done_q && tst_ok_q); // R6
   AST_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) err_i |=> irq_err_q && tst_abt_q); // R9
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n) (wr_cmd && host_wdata[CMD_STOP_B]) |=> !run_q); // R2
endmodule

// File: rtl/txl_fetch.sv
module txl_fetch
   import txl_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int MIN_FRAME = 64,
   parameter bit PAD_EN    = 1'b1,
   localparam int PAGE_W   = ADDR_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              abort_i,
   input  logic              fault_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [7:0]        mem_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   input  logic              tx_ready
);
   txl_state_e        state_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  stored_q, limit_q, idx_q, total_w;
   logic [7:0]        data_q;
   logic              accept, last;

   generate
      if (PAD_EN) begin : g_pad
         assign total_w = (count_i < CNT_W'(MIN_FRAME)) ? CNT_W'(MIN_FRAME) : count_i;
      end else begin : g_nopad
         assign total_w = count_i;
      end
   endgenerate

   assign busy_o   = (state_q != ST_IDLE);
   assign err_o    = busy_o && (fault_i || abort_i);
   assign accept   = (state_q == ST_SEND) && tx_ready;
   assign last     = ((idx_q + 1'b1) == limit_q);
   assign done_o   = (!err_o && accept && last) || (go_i && !busy_o && (total_w == '0));
   assign mem_rd   = (state_q == ST_FETCH) && !err_o && (idx_q < stored_q);
   assign mem_addr = base_q + idx_q[ADDR_W-1:0];
   assign tx_valid = (state_q == ST_SEND);
   assign tx_data  = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         base_q   <= '0;
         stored_q <= '0;
         limit_q  <= '0;
         idx_q    <= '0;
         data_q   <= '0;
      end else if (err_o) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go_i && (total_w != '0)) begin
                  state_q  <= ST_FETCH;
                  base_q   <= {page_i, 8'h00};
                  stored_q <= count_i;
                  limit_q  <= total_w;
                  idx_q    <= '0;
               end
            end
            ST_FETCH: begin
               if (idx_q < stored_q) begin
                  state_q <= ST_LOAD;
               end else begin
                  data_q  <= '0;
                  state_q <= ST_SEND;
               end
            end
            ST_LOAD: begin
               data_q  <= mem_rdata;
               state_q <= ST_SEND;
            end
            ST_SEND: begin
               if (accept) begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= last ? ST_IDLE : ST_FETCH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !mem_rd); // R3
   AST_RD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> (idx_q < stored_q)); // R4
   AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !fault_i && !abort_i) |=> (tx_valid && $stable(tx_data))); // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !busy_o); // R6
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && (idx_q >= stored_q)) |-> (tx_data == 8'h00)); // R7
   AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && fault_i) |=> (!tx_valid && !busy_o)); // R9
endmodule

// File: rtl/pkt_tx_launcher.sv
module pkt_tx_launcher
   import txl_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int MIN_FRAME = 64,
   parameter bit PAD_EN    = 1'b1,
   localparam int PAGE_W   = ADDR_W - 8,
   localparam int CNT_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        host_addr,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [7:0]        mem_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic              tx_fault
);
   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("pkt_tx_launcher: ADDR_W must lie in 9..16");
      end
      if (MIN_FRAME < 1 || MIN_FRAME > 65535) begin : g_bad_min
         $error("pkt_tx_launcher: MIN_FRAME must lie in 1..65535");
      end
   endgenerate

   logic              go, abort, busy, done, err;
   logic [PAGE_W-1:0] page;
   logic [CNT_W-1:0]  count;

   txl_regs #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .busy_i(busy), .done_i(done), .err_i(err),
      .go_o(go), .abort_o(abort), .page_o(page), .count_o(count)
   );

   txl_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MIN_FRAME(MIN_FRAME), .PAD_EN(PAD_EN)) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .go_i(go), .abort_i(abort), .fault_i(tx_fault), .page_i(page), .count_i(count),
      .busy_o(busy), .done_o(done), .err_o(err),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
   );

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R9
   AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) go |-> !busy); // R8
endmodule

// File: tb/pkt_tx_launcher_bench.sv
module pkt_tx_launcher_bench;
   localparam int CAP = 8192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic [7:0]  mem_rdata = '0;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic        tx_fault = 1'b0;

   int n_chk = 0, n_err = 0, cyc = 0;
   int cap_n = 0;
   logic [7:0] cap [CAP];
   int rdy_mode = 0;
   int watch_en = 0, watch_at = -1, watch_next = 0;

   always #10 clk = ~clk;

   pkt_tx_launcher u_pkt_tx_launcher (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_fault(tx_fault)
   );

   function automatic logic [7:0] byte_at(logic [15:0] a);
      return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] exp_byte(logic [7:0] page, int cnt, int i);
      logic [15:0] a;
      a = {page, 8'h00} + 16'(i);
      return (i < cnt) ? byte_at(a) : 8'h00;
   endfunction

   always @(posedge clk) if (mem_rd) mem_rdata <= byte_at(mem_addr);

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      tx_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 5) != 0);
      if (watch_next) begin
         chk("R6", "busy bit one cycle after last accept", int'(host_rdata[2]), 0);
         watch_next = 0;
      end
      if (tx_valid && tx_ready) begin
         if (cap_n < CAP) cap[cap_n] = tx_data;
         cap_n++;
         if (watch_en != 0 && cap_n == watch_at) begin
            chk("R6", "busy bit while last byte pending", int'(host_rdata[2]), 1);
            watch_next = 1;
         end
      end
   end

   task automatic summary_and_end();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_err++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
         summary_and_end();
      end
   end

   task automatic hw(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_addr = '0;
   endtask

   task automatic hr(logic [3:0] a, output logic [7:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
      host_addr = '0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         host_addr = '0;
         #1;
         if (host_rdata[2] == 1'b0) return;
      end
      chk("R6", "frame end timeout", 1, 0);
   endtask

   task automatic launch(logic [7:0] page, int cnt, output int base);
      hw(4'h4, page);
      hw(4'h5, 8'(cnt));
      hw(4'h6, 8'(cnt >> 8));
      base = cap_n;
      hw(4'h0, 8'h06);
   endtask

   task automatic check_frame(string req, logic [7:0] page, int cnt, int base);
      int total, bad;
      total = (cnt < 64) ? 64 : cnt;
      bad = -1;
      chk(req, "frame byte total", cap_n - base, total);
      for (int i = 0; i < total; i++)
         if (bad < 0 && (base + i) < CAP && cap[base + i] !== exp_byte(page, cnt, i)) bad = i;
      n_chk++;
      if (bad >= 0) begin
         n_err++;
         $display("FAIL %s frame byte %0d: actual 0x%0h expected 0x%0h",
                  req, bad, cap[base + bad], exp_byte(page, cnt, bad));
      end
   endtask

   initial begin
      logic [7:0] rd;
      int base, cnt;
      logic [7:0] pg;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      hr(4'h0, rd); chk("R1", "command after reset", rd, 8'h01);
      hr(4'h7, rd); chk("R1", "irq status after reset", rd, 8'h00);
      chk("R1", "tx_valid/mem_rd in reset", int'({tx_valid, mem_rd}), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      hr(4'h0, rd); chk("R1", "command after reset release", rd, 8'h01);

      // R2: launch bit while stopped, without START, does nothing
      hw(4'h4, 8'h10); hw(4'h5, 8'd20); hw(4'h6, 8'h00);
      base = cap_n;
      hw(4'h0, 8'h04);
      repeat (20) @(negedge clk);
      hr(4'h0, rd); chk("R2", "launch without START ignored", rd, 8'h01);
      chk("R2", "no bytes sent without START", cap_n - base, 0);
      hw(4'h0, 8'h07);
      repeat (20) @(negedge clk);
      hr(4'h0, rd); chk("R2", "launch with STOP ignored", rd, 8'h01);
      chk("R2", "no bytes sent with STOP", cap_n - base, 0);
      hw(4'h0, 8'h02);
      hr(4'h0, rd); chk("R2", "started readback", rd, 8'h02);
      hw(4'h0, 8'h04);
      repeat (10) @(negedge clk);
      hr(4'h0, rd); chk("R2", "launch bit alone while started ignored", rd, 8'h02);

      // R3/R4/R5/R11: normal frame under random back-pressure
      rdy_mode = 1;
      launch(8'h12, 100, base);
      hr(4'h0, rd); chk("R3", "busy bit after launch", rd, 8'h06);
      wait_idle();
      check_frame("R4", 8'h12, 100, base);
      hr(4'h4, rd); chk("R11", "offset 4 read is status, not page", rd, 8'h01);
      hr(4'h7, rd); chk("R6", "done interrupt bit", rd, 8'h02);
      hw(4'h7, 8'hFF);

      // R6: exact busy-fall cycle
      rdy_mode = 0;
      hw(4'h4, 8'h21); hw(4'h5, 8'd70); hw(4'h6, 8'h00);
      base = cap_n;
      watch_at = base + 70; watch_en = 1;
      hw(4'h0, 8'h06);
      wait_idle();
      repeat (2) @(negedge clk);
      watch_en = 0;
      check_frame("R5", 8'h21, 70, base);
      hr(4'h7, rd); chk("R6", "done bit with busy fall", rd, 8'h02);
      hw(4'h7, 8'hFF);

      // R7: padding edges
      launch(8'h33, 10, base); wait_idle(); check_frame("R7", 8'h33, 10, base);
      launch(8'h34, 0, base); wait_idle(); check_frame("R7", 8'h34, 0, base);
      launch(8'h35, 64, base); wait_idle(); check_frame("R7", 8'h35, 64, base);
      launch(8'hFF, 65, base); wait_idle(); check_frame("R7", 8'hFF, 65, base);
      hw(4'h7, 8'hFF);

      // R8: relaunch while busy is ignored
      rdy_mode = 1;
      launch(8'h03, 80, base);
      hw(4'h4, 8'h40); hw(4'h5, 8'd5); hw(4'h6, 8'h00); hw(4'h0, 8'h06);
      wait_idle();
      repeat (5) @(negedge clk);
      check_frame("R8", 8'h03, 80, base);
      // R10 setup: leave done bit set, then fault the next frame
      rdy_mode = 0;
      launch(8'h07, 200, base);
      repeat (40) @(negedge clk);
      tx_fault = 1'b1;
      @(negedge clk);
      tx_fault = 1'b0;
      chk("R9", "tx_valid after fault", int'(tx_valid), 0);
      hr(4'h0, rd); chk("R9", "busy clear after fault", rd, 8'h02);
      hr(4'h4, rd); chk("R9", "status aborted", rd, 8'h02);
      hr(4'h7, rd); chk("R9", "error bit set, done bit from earlier", rd, 8'h0A);
      chk("R9", "frame cut short", int'((cap_n - base) < 200), 1);
      hw(4'h7, 8'h02);
      hr(4'h7, rd); chk("R10", "clear only done bit", rd, 8'h08);
      hw(4'h7, 8'h08);
      hr(4'h7, rd); chk("R10", "clear error bit", rd, 8'h00);

      // R9: STOP mid-frame
      launch(8'h08, 150, base);
      repeat (20) @(negedge clk);
      hw(4'h0, 8'h01);
      chk("R9", "tx_valid after STOP", int'(tx_valid), 0);
      hr(4'h0, rd); chk("R9", "command after STOP", rd, 8'h01);
      hr(4'h7, rd); chk("R9", "error bit after STOP", rd, 8'h08);
      hw(4'h7, 8'hFF);
      hw(4'h0, 8'h02);

      // random frames
      for (int n = 0; n < 8; n++) begin
         pg = 8'($urandom);
         cnt = int'($urandom % 300);
         rdy_mode = int'($urandom % 2);
         launch(pg, cnt, base);
         wait_idle();
         check_frame("R5", pg, cnt, base);
         hr(4'h7, rd); chk("R6", "random frame done bit", rd, 8'h02);
         hw(4'h7, 8'hFF);
      end

      summary_and_end();
   end
endmodule